// File: doc/BRIEF.md
# Differential Clock Output Gating Control

This block decides, for each of four differential clock output pairs, whether the pair toggles, is parked in a driven stopped level, or is released to tristate. It takes two dedicated enable pins (one for the first pair, one for the last), an active-low stop pin, an active-low power-down pin and a polarity strap that flips the sense of all four of those pins. From a register block it takes a rate bit, two float-or-drive choices and two per-pair masks.

Everything runs on one logic clock. The distributed source clock arrives as a level on `src_i` that is sampled by that clock. The block can pass it through at full rate or halve it. The stop and power-down requests are resynchronized before use. Every per-pair state change waits until the selected output clock is in its low phase, so a pair never emits a shortened high pulse.

Top module: `diffclk_gate`

## Requirements
- R1: While reset is held, and after it until the first low-phase update, every pair reports `out_oe_o`=0, `out_p_o`=0 and `out_n_o`=0.
- R2: With `pol_inv_i`=0 the enable pins are active high and the stop and power-down pins are active low. With `pol_inv_i`=1 all four of these pins take the opposite sense.
- R3: `pin_en_first_i` gates pair 0 and `pin_en_last_i` gates pair 3. Pairs 1 and 2 have no enable pin. A pair whose pin enable is inactive is tristated.
- R4: `cfg_pair_en_i[i]`=1 enables pair i. When it is 0, pair i is tristated.
- R5: When power-down is asserted, every enabled pair stops. With `cfg_pwrdn_float_i`=1 the pair is tristated. With 0 it is driven stopped, which means `out_p_o`=1, `out_n_o`=0 and `out_oe_o`=1. Power-down takes precedence over stop.
- R6: Stop acts on pair i only when `cfg_stop_sel_i[i]`=1. A stopped pair is tristated if `cfg_stop_float_i`=1 and driven stopped (p=1, n=0) if it is 0.
- R7: A running pair has `out_oe_o`=1, has `out_p_o` following the selected clock, and has `out_n_o` as its complement. Whenever a pair is driven, `out_n_o` differs from `out_p_o`.
- R8: With `cfg_full_rate_i`=1 the output rises once per source rise. With 0 it rises once per two source rises.
- R9: A pair changes state only on a clock edge at which the selected clock is low. A stop request that arrives during a high phase leaves that high phase complete.
- R10: The stop and power-down pins pass through a two-flop synchronizer. A change on either pin, made while the clock is low, reaches the outputs on the third rising edge.
- R11: The enable pins and register bits are not synchronized. A pair disabled at a low-phase edge is tristated after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 1 | Source clock level, sampled by clk_i |
| pol_inv_i | input | 1 | Strap that inverts the polarity of the enable, stop and power-down pins |
| pin_en_first_i | input | 1 | Enable pin for pair 0 |
| pin_en_last_i | input | 1 | Enable pin for pair 3 |
| stop_ni | input | 1 | Stop request pin, active low at normal polarity |
| pwrdn_ni | input | 1 | Power-down pin, active low at normal polarity |
| cfg_full_rate_i | input | 1 | 1 = full rate, 0 = divide by two |
| cfg_stop_float_i | input | 1 | 1 = tristate stopped pairs, 0 = drive them stopped |
| cfg_pwrdn_float_i | input | 1 | 1 = tristate on power-down, 0 = drive stopped |
| cfg_pair_en_i | input | 4 | Per-pair register enable |
| cfg_stop_sel_i | input | 4 | Per-pair stop opt-in |
| out_p_o | output | 4 | True output of each pair |
| out_n_o | output | 4 | Complement output of each pair |
| out_oe_o | output | 4 | Drive enable of each pair; 0 = tristate |

## Verification
A pair state that is wrong shows up at the first sample taken in the low phase after the update edge. It appears as a wrong output enable, or as a complement that equals the true output. A wrong rate or divider phase shows up within two source periods as a wrong count of output rises. A synchronizer with the wrong depth moves the stop response one edge earlier or later than the third edge. A missing low-phase gate cuts the high phase during which a stop arrives.

// File: rtl/diffclk_gate.sv
module diffclk_gate #(
  parameter int NUM_PAIRS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 src_i,
  input  logic                 pol_inv_i,
  input  logic                 pin_en_first_i,
  input  logic                 pin_en_last_i,
  input  logic                 stop_ni,
  input  logic                 pwrdn_ni,
  input  logic                 cfg_full_rate_i,
  input  logic                 cfg_stop_float_i,
  input  logic                 cfg_pwrdn_float_i,
  input  logic [NUM_PAIRS-1:0] cfg_pair_en_i,
  input  logic [NUM_PAIRS-1:0] cfg_stop_sel_i,
  output logic [NUM_PAIRS-1:0] out_p_o,
  output logic [NUM_PAIRS-1:0] out_n_o,
  output logic [NUM_PAIRS-1:0] out_oe_o
);

  localparam int LAST = NUM_PAIRS - 1;

  typedef enum logic [1:0] {PM_FLOAT = 2'd0, PM_HOLD = 2'd1, PM_RUN = 2'd2} pair_mode_e;

  logic stop_raw, pwrdn_raw, stop_s, pwrdn_s;
  logic [SYNC_STAGES-1:0] stop_sync, pwrdn_sync;
  logic src_d, div_q, base_clk;
  logic [NUM_PAIRS-1:0] pin_ok;
  pair_mode_e mode_q [NUM_PAIRS];

  assign stop_raw  = ~stop_ni  ^ pol_inv_i;
  assign pwrdn_raw = ~pwrdn_ni ^ pol_inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_sync  <= '0;
      pwrdn_sync <= '0;
    end else begin
      stop_sync  <= {stop_sync[SYNC_STAGES-2:0], stop_raw};
      pwrdn_sync <= {pwrdn_sync[SYNC_STAGES-2:0], pwrdn_raw};
    end
  end

  assign stop_s  = stop_sync[SYNC_STAGES-1];
  assign pwrdn_s = pwrdn_sync[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_d <= 1'b0;
      div_q <= 1'b0;
    end else begin
      src_d <= src_i;
      div_q <= div_q ^ (src_i & ~src_d);
    end
  end

  assign base_clk = cfg_full_rate_i ? src_d : div_q;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    pair_mode_e want;

    if (g == 0) begin : g_first
      assign pin_ok[g] = pin_en_first_i ^ pol_inv_i;
    end else if (g == LAST) begin : g_last
      assign pin_ok[g] = pin_en_last_i ^ pol_inv_i;
    end else begin : g_mid
      assign pin_ok[g] = 1'b1;
    end

    always_comb begin
      if (!(pin_ok[g] && cfg_pair_en_i[g]))     want = PM_FLOAT;
      else if (pwrdn_s)                         want = cfg_pwrdn_float_i ? PM_FLOAT : PM_HOLD;
      else if (stop_s && cfg_stop_sel_i[g])     want = cfg_stop_float_i ? PM_FLOAT : PM_HOLD;
      else                                      want = PM_RUN;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mode_q[g] <= PM_FLOAT;
      else if (!base_clk) mode_q[g] <= want;
    end

    assign out_oe_o[g] = (mode_q[g] != PM_FLOAT);
    assign out_p_o[g]  = (mode_q[g] == PM_HOLD) | ((mode_q[g] == PM_RUN) & base_clk);
    assign out_n_o[g]  = (mode_q[g] == PM_RUN) & ~base_clk;

    AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      base_clk |=> $stable(mode_q[g])); // R9

    AST_FLOAT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_oe_o[g] |-> (!out_p_o[g] && !out_n_o[g])); // R1

    AST_PAIR_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_oe_o[g] |-> (out_p_o[g] != out_n_o[g])); // R7

    AST_DISABLE_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_pair_en_i[g] && !base_clk) |=> !out_oe_o[g]); // R11

    AST_PWRDN_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwrdn_s && !cfg_pwrdn_float_i && pin_ok[g] && cfg_pair_en_i[g] && !base_clk)
      |=> (out_oe_o[g] && out_p_o[g] && !out_n_o[g])); // R5
  end

endmodule

// File: tb/diffclk_gate_tb_top.sv
module diffclk_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src = 1'b0, pol = 1'b0, pin0 = 1'b1, pin3 = 1'b1, stop_n = 1'b1, pwrdn_n = 1'b1;
  logic full = 1'b1, stop_fl = 1'b0, pd_fl = 1'b0;
  logic [3:0] pair_en = 4'hF, stop_sel = 4'h0;
  logic [3:0] op, on, oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  diffclk_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .pol_inv_i(pol),
    .pin_en_first_i(pin0), .pin_en_last_i(pin3), .stop_ni(stop_n), .pwrdn_ni(pwrdn_n),
    .cfg_full_rate_i(full), .cfg_stop_float_i(stop_fl), .cfg_pwrdn_float_i(pd_fl),
    .cfg_pair_en_i(pair_en), .cfg_stop_sel_i(stop_sel),
    .out_p_o(op), .out_n_o(on), .out_oe_o(oe));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int pair, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pair %0d: {p,n,oe} actual %b expected %b", req, pair, act, exp);
    end
  endtask

  function automatic logic [2:0] pins(input int i);
    return {op[i], on[i], oe[i]};
  endfunction

  // 0 float, 1 hold, 2 run; tag names the deciding requirement
  function automatic int model(input int i, output string tag);
    logic e0, e3, st, pd, pok;
    e0 = pin0 ^ pol; e3 = pin3 ^ pol;
    st = ~stop_n ^ pol; pd = ~pwrdn_n ^ pol;
    pok = (i == 0) ? e0 : (i == 3) ? e3 : 1'b1;
    if (!pok) begin tag = pol ? "R2/R3" : "R3"; return 0; end
    if (!pair_en[i]) begin tag = "R4"; return 0; end
    if (pd) begin tag = pol ? "R2/R5" : "R5"; return pd_fl ? 0 : 1; end
    if (st && stop_sel[i]) begin tag = pol ? "R2/R6" : "R6"; return stop_fl ? 0 : 1; end
    tag = "R7";
    return 2;
  endfunction

  function automatic logic [2:0] level(input int m, input logic h);
    if (m == 2) return {h, ~h, 1'b1};
    if (m == 1) return 3'b101;
    return 3'b000;
  endfunction

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rises, m;
    logic prev;
    string tag;
    tick(3);
    for (int i = 0; i < 4; i++) chk("R1 reset", i, pins(i), 3'b000);
    rst_n = 1'b1;

    // exhaustive sweep of pin and float controls over enable masks
    for (int c = 0; c < 128; c++)
      for (int pe = 0; pe < 16; pe++)
        for (int ss = 0; ss < 4; ss++) begin
          {pol, pin0, pin3, stop_n, pwrdn_n, stop_fl, pd_fl} = 7'(c);
          pair_en = 4'(pe); stop_sel = 4'(ss * 5); src = 1'b0;
          tick(4);
          for (int i = 0; i < 4; i++) begin
            m = model(i, tag);
            chk(tag, i, pins(i), level(m, 1'b0));
          end
          src = 1'b1;
          tick(2);
          for (int i = 0; i < 4; i++) begin
            m = model(i, tag);
            chk(tag, i, pins(i), level(m, 1'b1));
          end
          src = 1'b0;
          tick(1);
        end

    // R10: stop reaches outputs on the third edge
    {pol, pin0, pin3, stop_n, pwrdn_n, stop_fl, pd_fl} = 7'b0111110;
    pair_en = 4'hF; stop_sel = 4'hF; src = 1'b0;
    tick(4);
    stop_n = 1'b0;
    tick(2);
    for (int i = 0; i < 4; i++) chk("R10 before sync", i, pins(i), 3'b011);
    tick(1);
    for (int i = 0; i < 4; i++) chk("R10 after sync", i, pins(i), 3'b000);

    // R9: stop arriving in high phase keeps the pulse whole
    stop_n = 1'b1;
    tick(4);
    src = 1'b1;
    tick(1);
    stop_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      chk("R9 high kept", 1, pins(1), 3'b101);
    end
    src = 1'b0;
    tick(1);
    chk("R9 low before update", 1, pins(1), 3'b011);
    tick(1);
    chk("R9 parked after low", 1, pins(1), 3'b000);

    // R8: rate selection
    stop_n = 1'b1;
    tick(4);
    for (int r = 0; r < 2; r++) begin
      full = (r == 0);
      tick(4);
      prev = op[1];
      rises = 0;
      for (int p = 0; p < 8; p++) begin
        src = 1'b1;
        for (int k = 0; k < 2; k++) begin tick(1); if (op[1] && !prev) rises++; prev = op[1]; end
        src = 1'b0;
        for (int k = 0; k < 2; k++) begin tick(1); if (op[1] && !prev) rises++; prev = op[1]; end
      end
      tick(2);
      checks++;
      if (rises != (full ? 8 : 4)) begin
        errors++;
        $display("FAIL R8 rate full=%0d: rises actual %0d expected %0d", full, rises, full ? 8 : 4);
      end
    end

    // R11: register disable floats at next low edge
    full = 1'b1; src = 1'b0;
    tick(4);
    pair_en = 4'b1011;
    tick(1);
    chk("R11 disable", 2, pins(2), 3'b000);
    chk("R11 neighbour", 1, pins(1), 3'b011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule